// File: doc/BRIEF.md
# Video Layer Priority Compositor

This block picks, for every pixel of a tile-based video generator, the one color code that goes to the display. It stacks three layers: a sprite plane on top, a pattern plane under it, and a backdrop at the bottom. The backdrop fills the border outside the active display area, and it also fills any pixel inside that area where both planes are transparent. Every color is a 4-bit code. Three of its bits select a hue and one sets the intensity. Code 0 means transparent, which leaves fifteen codes that can be seen.

The backdrop color sits in a register that software loads. A second register bit turns on external-video mode. In that mode the backdrop layer is replaced by an external pixel stream. Any pixel that a plane actually draws still wins over the external stream. Wherever neither plane draws, the external pixel passes through, and a select flag tells the analog stage downstream that the external source is in use.

The result is registered, so the output appears one pixel clock after its inputs. The select flag is registered on the same cycle as the color. Sync generation, analog encoding and color-burst handling live elsewhere.

Top module: `vlm_layer_mixer`

## Requirements
- R1: A synchronous active-low reset sets the output color to black (code 1), clears the select flag, loads black into the backdrop register and turns external-video mode off. A configuration write presented while reset is low is discarded.
- R2: Code 0 is transparent. Every nonzero code from 1 to 15 is visible and reaches the output unchanged, including its intensity bit.
- R3: Inside the active area, a nonzero sprite code is output whatever the pattern code is, with the select flag low.
- R4: Inside the active area, a transparent sprite code lets a nonzero pattern code through, with the select flag low.
- R5: With external-video mode off, a pixel inside the active area whose two plane codes are both 0 shows the backdrop register.
- R6: With external-video mode off, a pixel outside the active area shows the backdrop register, whatever the two plane codes are.
- R7: With external-video mode on, the external pixel code is output and the select flag is high in two cases: a pixel outside the active area, and a pixel inside the active area whose two plane codes are both 0.
- R8: With external-video mode on, a pixel inside the active area with a nonzero plane code shows that plane code by the priority of R3 and R4, with the select flag low.
- R9: The color and the select flag change exactly one clock after the inputs that produce them. Between edges they hold.
- R10: A configuration write (enable high) loads the backdrop color and the mode bit at a clock edge. A pixel presented in the same cycle as the write still uses the old values. The next pixel uses the new ones.
- R11: With external-video mode off, the external pixel input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_backdrop | input | 4 | Backdrop color value to load |
| cfg_ext_en | input | 1 | External-video mode bit to load |
| active | input | 1 | Pixel lies inside the active display area |
| spr_code | input | 4 | Sprite plane color code (0 means transparent) |
| pat_code | input | 4 | Pattern plane color code (0 means transparent) |
| ext_code | input | 4 | External video pixel code |
| pix_out | output | 4 | Composited color code, registered |
| ext_sel | output | 1 | High when pix_out carries the external pixel |

## Verification
The bench drives a sprite and a pattern that are both visible on the same pixel. A design with the priority reversed would show the pattern there. It drives border pixels with nonzero plane codes present, where a design that ignored the active flag would leak plane colors into the border. It writes the backdrop on the same cycle as a border pixel, which catches a write path that bypasses the register and lands one pixel early. In external mode it mixes transparent and visible plane pixels with a nonzero external stream. A design that gated on the mode alone would flood the external stream over drawn pixels, or would leave the select flag out of step with the color. A reset issued after the configuration has been changed must bring the backdrop back to black and turn the mode off.

// File: rtl/vlm_pkg.sv
// Package vlm_pkg: shared constants and types of the layer compositor.
// Assumes a 4-bit color code with 0 reserved as transparent and 1 as black.
package vlm_pkg;
    localparam int CODE_W = 4;
    localparam int NUM_PLANES = 2;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_CLEAR = code_t'(0);
    localparam code_t CODE_BLACK = code_t'(1);
endpackage

// File: rtl/vlm_cfg_regs.sv
// Module vlm_cfg_regs: holds the backdrop color and the external-video mode bit.
// Assumes a write strobe that is valid for one pixel clock. The new values
// become visible to the next pixel. Reset loads black and clears the mode.
module vlm_cfg_regs #(
    parameter int CODE_W = vlm_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wr_backdrop,
    input  logic              wr_ext_en,
    output logic [CODE_W-1:0] backdrop,
    output logic              ext_en
);
    localparam logic [CODE_W-1:0] BLACK = CODE_W'(1);

    // Load the configuration on a write, reset it to black with the mode off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            backdrop <= BLACK;
            ext_en   <= 1'b0;
        end else if (we) begin
            backdrop <= wr_backdrop;
            ext_en   <= wr_ext_en;
        end
    end
endmodule

// File: rtl/vlm_plane_pick.sv
// Module vlm_plane_pick: priority selection over the generated planes.
// Plane 0 has the highest priority. A plane whose code is zero is transparent
// and defers to the next plane. Outside the active area no plane is visible.
module vlm_plane_pick #(
    parameter int N      = vlm_pkg::NUM_PLANES,
    parameter int CODE_W = vlm_pkg::CODE_W
) (
    input  logic                     active,
    input  logic [N-1:0][CODE_W-1:0] planes,
    output logic                     hit,
    output logic [CODE_W-1:0]        code
);
    logic [N:0]             chain_hit;
    logic [N:0][CODE_W-1:0] chain_code;

    assign chain_hit[N]  = 1'b0;
    assign chain_code[N] = '0;

    // Build the chain from the lowest plane up, so a higher plane overrides.
    for (genvar i = N - 1; i >= 0; i--) begin : g_stage
        logic vis;
        assign vis           = active && (planes[i] != '0);
        assign chain_hit[i]  = vis | chain_hit[i+1];
        assign chain_code[i] = vis ? planes[i] : chain_code[i+1];
    end

    assign hit  = chain_hit[0];
    assign code = chain_code[0];
endmodule

// File: rtl/vlm_out_stage.sv
// Module vlm_out_stage: chooses between plane, backdrop and external pixel
// and registers the result together with the external-select flag.
// Assumes the plane result is already priority-resolved. Latency is one clock.
module vlm_out_stage #(
    parameter int CODE_W = vlm_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plane_hit,
    input  logic [CODE_W-1:0] plane_code,
    input  logic [CODE_W-1:0] backdrop,
    input  logic              ext_en,
    input  logic [CODE_W-1:0] ext_code,
    output logic [CODE_W-1:0] pix_out,
    output logic              ext_sel
);
    localparam logic [CODE_W-1:0] BLACK = CODE_W'(1);

    logic [CODE_W-1:0] nxt_code;
    logic              nxt_sel;

    // Decide which source fills the bottom layer and which layer wins.
    always_comb begin
        nxt_sel  = 1'b0;
        nxt_code = backdrop;
        if (plane_hit) begin
            nxt_code = plane_code;
        end else if (ext_en) begin
            nxt_code = ext_code;
            nxt_sel  = 1'b1;
        end
    end

    // Register the color and the select flag on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= BLACK;
            ext_sel <= 1'b0;
        end else begin
            pix_out <= nxt_code;
            ext_sel <= nxt_sel;
        end
    end
endmodule

// File: rtl/vlm_layer_mixer.sv
// Module vlm_layer_mixer: top of the video layer priority compositor.
// The sprite plane sits over the pattern plane, and both sit over the
// backdrop or the external video. Assumes one pixel per clock. The output
// is registered.
module vlm_layer_mixer #(
    parameter int CODE_W = vlm_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_backdrop,
    input  logic              cfg_ext_en,
    input  logic              active,
    input  logic [CODE_W-1:0] spr_code,
    input  logic [CODE_W-1:0] pat_code,
    input  logic [CODE_W-1:0] ext_code,
    output logic [CODE_W-1:0] pix_out,
    output logic              ext_sel
);
    localparam int NPL = vlm_pkg::NUM_PLANES;

    logic [CODE_W-1:0]          backdrop;
    logic                       ext_en;
    logic [NPL-1:0][CODE_W-1:0] planes;
    logic                       plane_hit;
    logic [CODE_W-1:0]          plane_code;

    // Index 0 is the sprite plane, which has the highest priority.
    assign planes = {pat_code, spr_code};

    vlm_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .wr_backdrop (cfg_backdrop),
        .wr_ext_en   (cfg_ext_en),
        .backdrop    (backdrop),
        .ext_en      (ext_en)
    );

    vlm_plane_pick #(.N(NPL), .CODE_W(CODE_W)) u_pick (
        .active (active),
        .planes (planes),
        .hit    (plane_hit),
        .code   (plane_code)
    );

    vlm_out_stage #(.CODE_W(CODE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .plane_hit  (plane_hit),
        .plane_code (plane_code),
        .backdrop   (backdrop),
        .ext_en     (ext_en),
        .ext_code   (ext_code),
        .pix_out    (pix_out),
        .ext_sel    (ext_sel)
    );
endmodule

// File: rtl/vlm_layer_mixer_chk.sv
// Module vlm_layer_mixer_chk: port-level properties of the compositor,
// bound to every instance of the top module.
module vlm_layer_mixer_chk #(
    parameter int CODE_W = vlm_pkg::CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic [CODE_W-1:0] spr_code,
    input logic [CODE_W-1:0] pat_code,
    input logic [CODE_W-1:0] ext_code,
    input logic [CODE_W-1:0] pix_out,
    input logic              ext_sel
);
    // R1: the first cycle after a reset edge shows black with no select.
    p_reset_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pix_out == CODE_W'(1)) && !ext_sel);

    // R3: a visible sprite wins one clock later.
    p_sprite_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && spr_code != '0) |=> (pix_out == $past(spr_code)) && !ext_sel);

    // R4: a transparent sprite lets a visible pattern through.
    p_pattern_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && spr_code == '0 && pat_code != '0) |=>
            (pix_out == $past(pat_code)) && !ext_sel);

    // R7: whenever the select flag is high, the color is the external pixel.
    p_ext_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> (pix_out == $past(ext_code)));

    // R8: a drawn plane pixel never selects the external source.
    p_no_ext_on_drawn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (spr_code != '0 || pat_code != '0)) |=> !ext_sel);
endmodule

bind vlm_layer_mixer vlm_layer_mixer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .spr_code (spr_code),
    .pat_code (pat_code),
    .ext_code (ext_code),
    .pix_out  (pix_out),
    .ext_sel  (ext_sel)
);

// File: tb/test_vlm_layer_mixer.sv
// Bench for vlm_layer_mixer: a behavioural reference model is advanced at
// every edge and compared with the outputs at every falling edge.
module test_vlm_layer_mixer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_backdrop = 4'd0;
    logic       cfg_ext_en = 1'b0;
    logic       active = 1'b0;
    logic [3:0] spr_code = 4'd0;
    logic [3:0] pat_code = 4'd0;
    logic [3:0] ext_code = 4'd0;
    logic [3:0] pix_out;
    logic       ext_sel;

    int checks = 0;
    int fails  = 0;

    // Reference state
    int m_bd  = 1;
    int m_ext = 0;
    int e_pix = 1;
    int e_sel = 0;

    always #(PERIOD/2) clk = ~clk;

    vlm_layer_mixer i_vlm_layer_mixer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_backdrop(cfg_backdrop),
        .cfg_ext_en(cfg_ext_en), .active(active), .spr_code(spr_code),
        .pat_code(pat_code), .ext_code(ext_code), .pix_out(pix_out), .ext_sel(ext_sel)
    );

    task automatic check(input string tag, input int got_pix, input int got_sel,
                         input int exp_pix, input int exp_sel);
        checks++;
        if (got_pix != exp_pix || got_sel != exp_sel) begin
            fails++;
            $display("FAIL %s: pix_out=%0d ext_sel=%0d expected pix_out=%0d ext_sel=%0d",
                     tag, got_pix, got_sel, exp_pix, exp_sel);
        end
    endtask

    // Label a pixel by the requirement whose rule decides it.
    function automatic string auto_tag(input logic a, input int s, input int p, input int x);
        if (a && s != 0) return "R3";
        if (a && p != 0) return (x != 0) ? "R8" : "R4";
        if (x != 0)      return "R7";
        return a ? "R5" : "R6";
    endfunction

    // One pixel clock: drive at the falling edge, model at the rising edge, compare.
    task automatic step(input logic a, input int s, input int p, input int x,
                        input logic we, input int bd, input int xe, input string tag);
        string t;
        active = a; spr_code = 4'(s); pat_code = 4'(p); ext_code = 4'(x);
        cfg_we = we; cfg_backdrop = 4'(bd); cfg_ext_en = (xe != 0);
        #1;
        check("R9", int'(pix_out), int'(ext_sel), e_pix, e_sel); // holds until edge
        t = (tag == "") ? auto_tag(a, s, p, m_ext) : tag;
        @(posedge clk);
        if (!rst_n) begin
            e_pix = 1; e_sel = 0; m_bd = 1; m_ext = 0;
        end else begin
            if (a && s != 0)      begin e_pix = s; e_sel = 0; end
            else if (a && p != 0) begin e_pix = p; e_sel = 0; end
            else if (m_ext != 0)  begin e_pix = x; e_sel = 1; end
            else                  begin e_pix = m_bd; e_sel = 0; end
            if (we) begin m_bd = bd; m_ext = xe; end
        end
        @(negedge clk);
        check(t, int'(pix_out), int'(ext_sel), e_pix, e_sel);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset with a write pending, which must be discarded
        rst_n = 1'b0;
        step(1'b1, 5, 6, 7, 1'b1, 9, 1, "R1");
        step(1'b0, 0, 0, 7, 1'b1, 9, 1, "R1");
        rst_n = 1'b1;
        step(1'b0, 3, 4, 7, 1'b0, 0, 0, "R1");   // border shows black, mode off
        // R2: every visible code passes unchanged as a sprite
        for (int c = 1; c < 16; c++) step(1'b1, c, 0, 0, 1'b0, 0, 0, "R2");
        for (int c = 1; c < 16; c++) step(1'b1, 0, c, 0, 1'b0, 0, 0, "R2");
        // R3: sprite over a visible pattern
        step(1'b1, 9, 4, 0, 1'b0, 0, 0, "R3");
        // R5: both transparent shows backdrop (black)
        step(1'b1, 0, 0, 0, 1'b0, 0, 0, "R5");
        // R10: write backdrop on a border pixel; old value this pixel, new next
        step(1'b0, 0, 0, 0, 1'b1, 12, 0, "R10");
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, "R10");
        // R6: border ignores plane codes
        step(1'b0, 7, 8, 0, 1'b0, 0, 0, "R6");
        // R11: external input ignored while mode is off
        step(1'b0, 0, 0, 13, 1'b0, 0, 0, "R11");
        step(1'b1, 0, 0, 14, 1'b0, 0, 0, "R11");
        // R10: turn on external mode; same pixel still uses backdrop
        step(1'b0, 0, 0, 11, 1'b1, 12, 1, "R10");
        step(1'b0, 0, 0, 11, 1'b0, 0, 0, "R7");
        step(1'b1, 0, 0, 10, 1'b0, 0, 0, "R7");
        step(1'b1, 0, 5, 10, 1'b0, 0, 0, "R8");
        step(1'b1, 6, 5, 10, 1'b0, 0, 0, "R8");
        step(1'b1, 0, 0, 0, 1'b0, 0, 0, "R7");
        // Random traffic with occasional configuration writes
        for (int i = 0; i < 400; i++) begin
            logic w;
            w = ($urandom_range(0, 15) == 0);
            step(1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0 ? int'($urandom_range(1, 15)) : 0,
                 $urandom_range(0, 2) == 0 ? int'($urandom_range(1, 15)) : 0,
                 int'($urandom_range(0, 15)), w, int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 1)), "");
        end
        // R1: reset after configuration changed restores black and mode off
        step(1'b0, 0, 0, 3, 1'b1, 6, 1, "R10");
        rst_n = 1'b0;
        step(1'b0, 0, 0, 3, 1'b0, 0, 0, "R1");
        rst_n = 1'b1;
        step(1'b0, 0, 0, 3, 1'b0, 0, 0, "R1");
        step(1'b1, 0, 0, 3, 1'b0, 0, 0, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule